// File: doc/BRIEF.md
# Chroma Threshold Skin Pixel Classifier

This block sits directly behind a camera capture interface and turns a stream of 12-bit RGB444 pixels into a one-bit skin mask. Every clock may carry one pixel, marked by a valid strobe. The block derives the red-minus-green chroma term of a reversible integer colour transform. It labels the pixel as skin when that term falls strictly inside a fixed window. The window bounds are given on an 8-bit scale and are shifted down to the 4-bit channel precision of the input.

Each classified pixel leaves the block one clock later as a mask bit, with its own valid strobe and a linear write address. A frame buffer can store it with no further logic. The address counter restarts on a frame-start pulse, counts only valid pixels, and wraps after the last pixel of a frame. With the default 640 by 480 frame, the address is 19 bits wide. The luma and blue-difference terms of the transform play no part in the decision, so they are not built.

Top module: `skin_classifier`

## Requirements
- R1: While reset is asserted and after its release with no pixel applied, `mask_valid`, `mask_skin` and `mask_addr` are all 0.
- R2: `mask_valid` is high in the cycle after a clock edge that sampled `pix_valid` high, and low in the cycle after an edge that sampled it low.
- R3: The input carries red in bits [11:8], green in bits [7:4] and blue in bits [3:0]. The chroma is U = R - G, a signed value. The pixel is skin (`mask_skin` = 1) exactly when LO < U < HI, where LO = 10 >> 4 = 0 and HI = 74 >> 4 = 4. Both comparisons are strict, so U in {1, 2, 3} is skin.
- R4: A pixel with R < G (negative U) is always classified as non-skin.
- R5: The blue bits [3:0] have no effect on `mask_skin`.
- R6: Each valid pixel that is not on a frame start gets the address one greater than the previous valid pixel. Cycles without a valid pixel do not advance the address.
- R7: A valid pixel presented in the same cycle as `frame_start` gets address 0, and the next valid pixel gets address 1. A `frame_start` with no valid pixel makes the next valid pixel address 0.
- R8: The valid pixel after the one at address FRAME_W*FRAME_H-1 gets address 0.
- R9: In a cycle after an edge with `pix_valid` low, `mask_skin` and `mask_addr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| frame_start | input | 1 | Restarts the pixel address at 0 |
| pix_valid | input | 1 | Qualifies pix_rgb in this cycle |
| pix_rgb | input | 12 | RGB444 pixel: R [11:8], G [7:4], B [3:0] |
| mask_valid | output | 1 | Mask bit and address are new this cycle |
| mask_skin | output | 1 | 1 = skin, 0 = non-skin |
| mask_addr | output | ADDR_W (19 by default) | Linear frame-buffer address of the mask bit |

## Verification
A frame-start pulse and a valid pixel can arrive on the same edge. The address restart and the address increment then compete, and the pixel must take address 0 while its successor takes 1. The bench drives frame-start with a valid pixel, with an idle cycle, and exactly on the wrap pixel. It compares each resulting address against a counter the bench keeps itself. Around these collisions it sweeps all 4096 pixel codes, with and without idle gaps, over a 32-pixel frame so that wraps occur often.

// File: rtl/skin_pkg.sv
package skin_pkg;

  localparam int CH_W  = 4;
  localparam int SRC_W = 8;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb444_t;

endpackage

// File: rtl/skin_chroma_u.sv
module skin_chroma_u
  import skin_pkg::*;
(
  input  logic [CH_W-1:0]        red,
  input  logic [CH_W-1:0]        green,
  output logic signed [CH_W:0]   chroma_u
);

  // Red-difference term of the reversible integer transform.
  always_comb begin
    chroma_u = $signed({1'b0, red}) - $signed({1'b0, green});
  end

endmodule

// File: rtl/skin_window_cmp.sv
module skin_window_cmp
  import skin_pkg::*;
#(
  parameter int LO8 = 10,
  parameter int HI8 = 74
) (
  input  logic signed [CH_W:0] chroma_u,
  output logic                 in_window
);

  localparam int SHIFT = SRC_W - CH_W;
  localparam logic signed [CH_W:0] LO_C = (CH_W+1)'(LO8 >> SHIFT);
  localparam logic signed [CH_W:0] HI_C = (CH_W+1)'(HI8 >> SHIFT);

  always_comb begin
    in_window = (chroma_u > LO_C) && (chroma_u < HI_C);
  end

endmodule

// File: rtl/skin_addr_gen.sv
module skin_addr_gen #(
  parameter int FRAME_PIX = 307200,
  parameter int ADDR_W    = $clog2(FRAME_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_valid,
  output logic [ADDR_W-1:0] pix_addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_PIX - 1);

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    pix_addr = frame_start ? '0 : cnt_q;
    cnt_en   = pix_valid || frame_start;
    if (pix_valid) begin
      cnt_d = (pix_addr == LAST) ? '0 : pix_addr + 1'b1;
    end else begin
      cnt_d = pix_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_addr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/skin_classifier.sv
module skin_classifier
  import skin_pkg::*;
#(
  parameter int FRAME_W   = 640,
  parameter int FRAME_H   = 480,
  parameter int LO8       = 10,
  parameter int HI8       = 74,
  parameter int FRAME_PIX = FRAME_W * FRAME_H,
  parameter int ADDR_W    = $clog2(FRAME_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [11:0]       pix_rgb,
  output logic              mask_valid,
  output logic              mask_skin,
  output logic [ADDR_W-1:0] mask_addr
);

  rgb444_t               pix;
  logic signed [CH_W:0]  chroma_u;
  logic                  skin_c;
  logic [ADDR_W-1:0]     pix_addr;
  logic                  unused_blue;

  assign pix         = rgb444_t'(pix_rgb);
  assign unused_blue = ^pix.b;

  skin_chroma_u u_chroma (
    .red      (pix.r),
    .green    (pix.g),
    .chroma_u (chroma_u)
  );

  skin_window_cmp #(
    .LO8 (LO8),
    .HI8 (HI8)
  ) u_cmp (
    .chroma_u  (chroma_u),
    .in_window (skin_c)
  );

  skin_addr_gen #(
    .FRAME_PIX (FRAME_PIX),
    .ADDR_W    (ADDR_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .pix_addr    (pix_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_valid <= 1'b0;
    end else begin
      mask_valid <= pix_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_skin <= 1'b0;
      mask_addr <= '0;
    end else if (pix_valid) begin
      mask_skin <= skin_c;
      mask_addr <= pix_addr;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> mask_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !mask_valid);

  assert_negative_u_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (pix_rgb[11:8] < pix_rgb[7:4])) |=> !mask_skin);

  assert_start_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && frame_start) |=> (mask_addr == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(mask_skin) && $stable(mask_addr)));

endmodule

// File: tb/tb_skin_classifier.sv
module tb_skin_classifier;

  localparam int FW    = 8;
  localparam int FH    = 4;
  localparam int NPIX  = FW * FH;
  localparam int AW    = $clog2(NPIX);

  logic          clk;
  logic          rst_n;
  logic          frame_start;
  logic          pix_valid;
  logic [11:0]   pix_rgb;
  logic          mask_valid;
  logic          mask_skin;
  logic [AW-1:0] mask_addr;

  int n_vec;
  int n_bad;
  int model_cnt;
  int exp_addr;
  bit exp_skin;
  bit done;

  skin_classifier #(
    .FRAME_W (FW),
    .FRAME_H (FH)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .pix_rgb     (pix_rgb),
    .mask_valid  (mask_valid),
    .mask_skin   (mask_skin),
    .mask_addr   (mask_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit ref_skin(input logic [11:0] d);
    int u;
    u = int'(d[11:8]) - int'(d[7:4]);
    return (u > (10 / 16)) && (u < (74 / 16));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at a falling edge, check at the next falling edge.
  task automatic step(input bit fs, input bit v, input logic [11:0] d);
    int base;
    string atag;
    string btag;
    frame_start = fs;
    pix_valid   = v;
    pix_rgb     = d;
    base = fs ? 0 : model_cnt;
    atag = "R9";
    btag = "R9";
    if (v) begin
      exp_skin = ref_skin(d);
      exp_addr = base;
      btag = (d[11:8] < d[7:4]) ? "R4" : "R3,R5";
      if (fs) atag = "R7";
      else if (model_cnt == 0) atag = "R8,R6";
      else atag = "R6";
      model_cnt = (base == NPIX - 1) ? 0 : base + 1;
    end else begin
      model_cnt = base;
    end
    @(negedge clk);
    check("R2 mask_valid", int'(mask_valid), int'(v));
    check({btag, " mask_skin"}, int'(mask_skin), int'(exp_skin));
    check({atag, " mask_addr"}, int'(mask_addr), exp_addr);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    model_cnt = 0; exp_addr = 0; exp_skin = 0;
    rst_n = 1'b0; frame_start = 1'b0; pix_valid = 1'b0; pix_rgb = '0;
    repeat (3) @(negedge clk);
    check("R1 mask_valid", int'(mask_valid), 0);
    check("R1 mask_skin", int'(mask_skin), 0);
    check("R1 mask_addr", int'(mask_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mask_valid", int'(mask_valid), 0);

    // Full sweep, back to back; frame start with the first pixel (R7).
    for (int i = 0; i < 4096; i++) step(i == 0, 1'b1, 12'(i));
    // Sweep again with idle gaps every other cycle (R6, R9).
    for (int i = 0; i < 4096; i++) begin
      step(1'b0, 1'b1, 12'(4095 - i));
      step(1'b0, 1'b0, 12'(i * 7));
    end
    // Frame start with no pixel, then pixels (R7).
    step(1'b0, 1'b1, 12'h310);
    step(1'b1, 1'b0, 12'h000);
    step(1'b0, 1'b1, 12'h2F0);
    step(1'b0, 1'b1, 12'h0A5);
    // Frame start mid-frame with a valid pixel, then a second one.
    step(1'b1, 1'b1, 12'h41C);
    step(1'b0, 1'b1, 12'h53C);
    // Run up to the last address and collide frame start with the wrap.
    while (model_cnt != NPIX - 1) step(1'b0, 1'b1, 12'h210);
    step(1'b1, 1'b1, 12'hF00);
    step(1'b0, 1'b1, 12'h100);
    // Blue independence at a skin and a non-skin chroma (R5).
    for (int b = 0; b < 16; b++) step(1'b0, 1'b1, {4'h6, 4'h4, 4'(b)});
    for (int b = 0; b < 16; b++) step(1'b0, 1'b1, {4'h9, 4'h4, 4'(b)});
    step(1'b0, 1'b0, 12'h000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule